// File: doc/BRIEF.md
# Byte-Lane Word Packer

This block sits between 32-bit words on the register side and a byte-at-a-time serial engine. On the transmit path it accepts a word together with four byte enables and hands the enabled bytes, one per handshake, to the serial engine. Disabled lanes are skipped. On the receive path it gathers incoming bytes into a word and offers only complete words. A byte marked as the last of a segment closes a short word early, and the lanes it never filled read as zero.

A single parameter sets the lane order. With `LSB_FIRST = 0` the high lane goes out first and the first received byte lands in the high lane. With `LSB_FIRST = 1` the low lane leads on both paths. The bit order inside each byte is not touched. A byte is passed whole and the serial engine shifts it most significant bit first. A transmit word with no byte enabled is consumed without producing any byte, and a one-cycle error pulse is raised. A synchronous clear discards the partial word on each path.

Both paths are small state machines. The transmit machine has two states. It sits in `TX_IDLE` while it waits for a word. It moves `TX_IDLE -> TX_SEND` when it accepts a word with at least one enable, and it returns `TX_SEND -> TX_IDLE` when the last enabled lane is handed over. The receive machine also has two states. It sits in `RX_FILL` while it collects bytes. It moves `RX_FILL -> RX_HOLD` on the fourth byte or on a byte flagged last, and it returns `RX_HOLD -> RX_FILL` when the word is taken. Clear forces both machines back to their first state.

Top module: `byte_lane_packer`

## Requirements
- R1: With `LSB_FIRST = 0`, the enabled bytes of a transmit word go out from lane 3 (bits 31:24) down to lane 0 (bits 7:0).
- R2: With `LSB_FIRST = 1`, the enabled bytes of a transmit word go out from lane 0 up to lane 3.
- R3: Only lanes whose `tx_be` bit is set are emitted. `tx_be[i]` covers bits 8i+7:8i. The enabled bytes go out on consecutive handshakes, with no handshake spent on a disabled lane.
- R4: A transmit word accepted with `tx_be = 0` produces no output byte. It raises `tx_err` for exactly the one cycle after the acceptance, and `tx_err` is low at all other times.
- R5: Received bytes fill lanes in the order set by `LSB_FIRST`, with the same lane order as transmit. A word is offered on `rx_word` only after four bytes, or earlier under R6.
- R6: A received byte with `rx_last` high closes the current word at once. Lanes that were not filled read as zero.
- R7: A cycle with `clear` high discards any transmit word in progress and any partly filled receive word. From the next cycle `tx_byte_valid` and `rx_word_valid` are low, and the next received byte starts a fresh word.
- R8: While `tx_byte_valid` is high and `tx_byte_ready` is low, `tx_byte` holds its value. The same holds for `rx_word_valid`, `rx_word_ready` and `rx_word`.
- R9: After reset `tx_ready` and `rx_byte_ready` are high, and `tx_byte_valid`, `rx_word_valid` and `tx_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous discard of partial words on both paths |
| tx_word | input | 32 | Transmit word |
| tx_be | input | 4 | Byte enables of the transmit word, one per lane |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word accepted this cycle if valid |
| tx_byte | output | 8 | Byte toward the serial engine |
| tx_byte_valid | output | 1 | `tx_byte` holds a byte |
| tx_byte_ready | input | 1 | Serial engine takes the byte |
| tx_err | output | 1 | One-cycle pulse after a word with no enabled byte |
| rx_byte | input | 8 | Byte from the serial engine |
| rx_byte_valid | input | 1 | `rx_byte` holds a byte |
| rx_last | input | 1 | This byte ends the segment |
| rx_byte_ready | output | 1 | Byte accepted this cycle if valid |
| rx_word | output | 32 | Assembled receive word |
| rx_word_valid | output | 1 | `rx_word` is complete |
| rx_word_ready | input | 1 | Consumer takes the word |

## Verification
The bench drives one stimulus into two copies of the block, one for each lane order. Any lane-order fault therefore shows up as a byte or word mismatch in only one of the two scoreboards. The transmit words cover all lanes enabled, and also single, split and adjacent enable patterns. These separate the correct skipping of lanes from emitting in fixed positions, and an all-clear pattern checks the error pulse. The receive side is fed full words, a two-byte flush and a one-byte flush, which tell the lane placement apart from the zero fill. Ready is toggled and then held low, so holding under back-pressure is exercised, and a clear is issued with a stuck transmit word and a half-filled receive word.

// File: rtl/lane_pack_pkg.sv
package lane_pack_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    typedef enum logic {
        RX_FILL = 1'b0,
        RX_HOLD = 1'b1
    } rx_state_e;
endpackage

// File: rtl/lane_tx_serializer.sv
module lane_tx_serializer
    import lane_pack_pkg::*;
#(
    parameter int unsigned LANES     = 4,
    parameter bit          LSB_FIRST = 1'b1,
    localparam int unsigned WORD_W   = LANES * BYTE_W,
    localparam int unsigned IDX_W    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [WORD_W-1:0] word_i,
    input  logic [LANES-1:0]  be_i,
    input  logic              valid_i,
    output logic              ready_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_valid_o,
    input  logic              byte_ready_i,
    output logic              err_o
);
    tx_state_e         state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic [LANES-1:0]  mask_q;
    logic [LANES-1:0]  lane_bit;
    logic [LANES-1:0]  mask_left;
    logic [IDX_W-1:0]  lane;
    logic              err_q;
    logic              found;
    logic              take_word;

    // Pick the first pending lane in the configured order.
    always_comb begin
        lane  = '0;
        found = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            int k;
            k = (LSB_FIRST != 1'b0) ? i : (LANES - 1 - i);
            if (!found && mask_q[k]) begin
                lane  = IDX_W'(k);
                found = 1'b1;
            end
        end
        lane_bit       = '0;
        lane_bit[lane] = 1'b1;
        mask_left      = mask_q & ~lane_bit;
    end

    assign take_word = (state_q == TX_IDLE) && valid_i && !clear;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (valid_i && (be_i != '0)) state_d = TX_SEND;
            TX_SEND: if (byte_ready_i && (mask_left == '0)) state_d = TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
        if (clear) state_d = TX_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            word_q  <= '0;
            mask_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= take_word && (be_i == '0);
            if (clear) begin
                mask_q <= '0;
            end else if (take_word && (be_i != '0)) begin
                word_q <= word_i;
                mask_q <= be_i;
            end else if ((state_q == TX_SEND) && byte_ready_i) begin
                mask_q <= mask_left;
            end
        end
    end

    always_comb begin
        ready_o      = (state_q == TX_IDLE) && !clear;
        byte_valid_o = (state_q == TX_SEND);
        byte_o       = word_q[lane*BYTE_W +: BYTE_W];
        err_o        = err_q;
    end
endmodule

// File: rtl/lane_rx_collector.sv
module lane_rx_collector
    import lane_pack_pkg::*;
#(
    parameter int unsigned LANES     = 4,
    parameter bit          LSB_FIRST = 1'b1,
    localparam int unsigned WORD_W   = LANES * BYTE_W,
    localparam int unsigned IDX_W    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              byte_valid_i,
    input  logic              byte_last_i,
    output logic              byte_ready_o,
    output logic [WORD_W-1:0] word_o,
    output logic              word_valid_o,
    input  logic              word_ready_i
);
    rx_state_e         state_q, state_d;
    logic [WORD_W-1:0] acc_q;
    logic [IDX_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  lane;
    logic              take;
    logic              close;

    assign lane  = (LSB_FIRST != 1'b0) ? cnt_q : (IDX_W'(LANES - 1) - cnt_q);
    assign take  = (state_q == RX_FILL) && byte_valid_i && !clear;
    assign close = take && ((cnt_q == IDX_W'(LANES - 1)) || byte_last_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_FILL: if (close) state_d = RX_HOLD;
            RX_HOLD: if (word_ready_i) state_d = RX_FILL;
            default: state_d = RX_FILL;
        endcase
        if (clear) state_d = RX_FILL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_FILL;
            acc_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (clear) begin
                acc_q <= '0;
                cnt_q <= '0;
            end else if (take) begin
                acc_q[lane*BYTE_W +: BYTE_W] <= byte_i;
                cnt_q <= close ? '0 : cnt_q + 1'b1;
            end else if ((state_q == RX_HOLD) && word_ready_i) begin
                acc_q <= '0;
            end
        end
    end

    always_comb begin
        byte_ready_o = (state_q == RX_FILL) && !clear;
        word_valid_o = (state_q == RX_HOLD);
        word_o       = acc_q;
    end
endmodule

// File: rtl/byte_lane_packer.sv
module byte_lane_packer #(
    parameter int unsigned LANES     = 4,
    parameter bit          LSB_FIRST = 1'b1,
    localparam int unsigned WORD_W   = LANES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [WORD_W-1:0] tx_word,
    input  logic [LANES-1:0]  tx_be,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [7:0]        tx_byte,
    output logic              tx_byte_valid,
    input  logic              tx_byte_ready,
    output logic              tx_err,
    input  logic [7:0]        rx_byte,
    input  logic              rx_byte_valid,
    input  logic              rx_last,
    output logic              rx_byte_ready,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_word_valid,
    input  logic              rx_word_ready
);
    lane_tx_serializer #(.LANES(LANES), .LSB_FIRST(LSB_FIRST)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (clear),
        .word_i       (tx_word),
        .be_i         (tx_be),
        .valid_i      (tx_valid),
        .ready_o      (tx_ready),
        .byte_o       (tx_byte),
        .byte_valid_o (tx_byte_valid),
        .byte_ready_i (tx_byte_ready),
        .err_o        (tx_err)
    );

    lane_rx_collector #(.LANES(LANES), .LSB_FIRST(LSB_FIRST)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (clear),
        .byte_i       (rx_byte),
        .byte_valid_i (rx_byte_valid),
        .byte_last_i  (rx_last),
        .byte_ready_o (rx_byte_ready),
        .word_o       (rx_word),
        .word_valid_o (rx_word_valid),
        .word_ready_i (rx_word_ready)
    );
endmodule

// File: rtl/byte_lane_packer_checker.sv
module byte_lane_packer_checker #(
    parameter int unsigned LANES = 4,
    localparam int unsigned WORD_W = LANES * 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear,
    input logic [LANES-1:0]  tx_be,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_byte,
    input logic              tx_byte_valid,
    input logic              tx_byte_ready,
    input logic              tx_err,
    input logic              rx_byte_ready,
    input logic [WORD_W-1:0] rx_word,
    input logic              rx_word_valid,
    input logic              rx_word_ready
);
    a_r4_err_after_empty_word: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err |-> $past(tx_valid && tx_ready && (tx_be == '0)));

    a_r4_empty_word_no_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && (tx_be == '0)) |=> !tx_byte_valid);

    a_r7_clear_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!tx_byte_valid && !rx_word_valid && !tx_err));

    a_r8_tx_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_byte_valid && !tx_byte_ready && !clear) |=> (tx_byte_valid && $stable(tx_byte)));

    a_r8_rx_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_word_valid && !rx_word_ready && !clear) |=> (rx_word_valid && $stable(rx_word)));

    a_r5_no_byte_while_holding: assert property (@(posedge clk) disable iff (!rst_n)
        rx_word_valid |-> !rx_byte_ready);

    a_r3_no_word_while_sending: assert property (@(posedge clk) disable iff (!rst_n)
        tx_byte_valid |-> !tx_ready);
endmodule

bind byte_lane_packer byte_lane_packer_checker #(.LANES(LANES)) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear         (clear),
    .tx_be         (tx_be),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .tx_byte       (tx_byte),
    .tx_byte_valid (tx_byte_valid),
    .tx_byte_ready (tx_byte_ready),
    .tx_err        (tx_err),
    .rx_byte_ready (rx_byte_ready),
    .rx_word       (rx_word),
    .rx_word_valid (rx_word_valid),
    .rx_word_ready (rx_word_ready)
);

// File: tb/test_byte_lane_packer.sv
`timescale 1ns/1ps
module test_byte_lane_packer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear = 1'b0;
    logic [31:0] tx_word = '0;
    logic [3:0]  tx_be = '0;
    logic        tx_valid = 1'b0;
    logic        tx_byte_ready = 1'b1;
    logic [7:0]  rx_byte = '0;
    logic        rx_byte_valid = 1'b0;
    logic        rx_last = 1'b0;
    logic        rx_word_ready = 1'b1;

    // index 0: low lane first, index 1: high lane first
    logic        txr [2];
    logic [7:0]  txb [2];
    logic        txv [2];
    logic        txe [2];
    logic        rxr [2];
    logic [31:0] rxw [2];
    logic        rxv [2];

    always #10 clk = ~clk;

    byte_lane_packer #(.LSB_FIRST(1'b1)) i_byte_lane_packer (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .tx_word(tx_word), .tx_be(tx_be), .tx_valid(tx_valid), .tx_ready(txr[0]),
        .tx_byte(txb[0]), .tx_byte_valid(txv[0]), .tx_byte_ready(tx_byte_ready), .tx_err(txe[0]),
        .rx_byte(rx_byte), .rx_byte_valid(rx_byte_valid), .rx_last(rx_last), .rx_byte_ready(rxr[0]),
        .rx_word(rxw[0]), .rx_word_valid(rxv[0]), .rx_word_ready(rx_word_ready));

    byte_lane_packer #(.LSB_FIRST(1'b0)) i_byte_lane_packer_msb (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .tx_word(tx_word), .tx_be(tx_be), .tx_valid(tx_valid), .tx_ready(txr[1]),
        .tx_byte(txb[1]), .tx_byte_valid(txv[1]), .tx_byte_ready(tx_byte_ready), .tx_err(txe[1]),
        .rx_byte(rx_byte), .rx_byte_valid(rx_byte_valid), .rx_last(rx_last), .rx_byte_ready(rxr[1]),
        .rx_word(rxw[1]), .rx_word_valid(rxv[1]), .rx_word_ready(rx_word_ready));

    int checks = 0;
    int errors = 0;
    int err_seen [2] = '{0, 0};
    int err_exp = 0;
    int rmode = 0;  // 0 always ready, 1 toggling, 2 stalled
    logic [7:0]  qtx [2][$];
    logic [31:0] qrx [2][$];
    logic [31:0] acc [2] = '{32'h0, 32'h0};
    int          rcnt = 0;
    logic        hold_tx [2] = '{1'b0, 1'b0};
    logic [7:0]  held_tx [2];
    logic        hold_rx [2] = '{1'b0, 1'b0};
    logic [31:0] held_rx [2];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // sink-side ready patterns
    always @(posedge clk) begin
        #1;
        case (rmode)
            0: begin tx_byte_ready = 1'b1; rx_word_ready = 1'b1; end
            1: begin tx_byte_ready = ~tx_byte_ready; rx_word_ready = ~rx_word_ready; end
            default: begin tx_byte_ready = 1'b0; rx_word_ready = 1'b0; end
        endcase
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < 2; k++) begin
                if (txe[k]) err_seen[k]++;
                if (clear) begin
                    hold_tx[k] = 1'b0;
                    hold_rx[k] = 1'b0;
                end else begin
                    if (hold_tx[k])
                        check(txv[k] && (txb[k] == held_tx[k]), "R8 tx hold", {24'h0, txb[k]}, {24'h0, held_tx[k]});
                    if (hold_rx[k])
                        check(rxv[k] && (rxw[k] == held_rx[k]), "R8 rx hold", rxw[k], held_rx[k]);
                    if (txv[k] && tx_byte_ready) begin
                        if (qtx[k].size() == 0)
                            check(1'b0, "R3 unexpected tx byte", {24'h0, txb[k]}, 32'h0);
                        else begin
                            logic [7:0] e;
                            e = qtx[k].pop_front();
                            check(txb[k] == e, k == 0 ? "R2 tx order" : "R1 tx order", {24'h0, txb[k]}, {24'h0, e});
                        end
                    end
                    if (rxv[k] && rx_word_ready) begin
                        if (qrx[k].size() == 0)
                            check(1'b0, "R5 unexpected rx word", rxw[k], 32'h0);
                        else begin
                            logic [31:0] e;
                            e = qrx[k].pop_front();
                            check(rxw[k] == e, "R5 R6 rx word", rxw[k], e);
                        end
                    end
                    hold_tx[k] = txv[k] && !tx_byte_ready;
                    held_tx[k] = txb[k];
                    hold_rx[k] = rxv[k] && !rx_word_ready;
                    held_rx[k] = rxw[k];
                end
            end
        end
    end

    task automatic send_word(input logic [31:0] w, input logic [3:0] be);
        for (int i = 0; i < 4; i++)
            if (be[i]) qtx[0].push_back(w[8*i +: 8]);
        for (int i = 3; i >= 0; i--)
            if (be[i]) qtx[1].push_back(w[8*i +: 8]);
        @(posedge clk); #1;
        tx_word = w; tx_be = be; tx_valid = 1'b1;
        @(negedge clk);
        while (!txr[0]) @(negedge clk);
        check(txr[0] == txr[1], "R3 ready alignment", {31'h0, txr[1]}, {31'h0, txr[0]});
        @(posedge clk); #1;
        tx_valid = 1'b0;
        if (be == 4'h0) begin
            err_exp++;
            @(negedge clk);
            check(txe[0] && txe[1], "R4 error pulse", {30'h0, txe[1], txe[0]}, 32'h3);
            @(negedge clk);
            check(!txe[0] && !txe[1] && !txv[0] && !txv[1], "R4 no byte, single pulse",
                  {30'h0, txv[0], txe[0]}, 32'h0);
        end
    endtask

    task automatic send_rx(input logic [7:0] b, input logic last);
        acc[0][8*rcnt +: 8] = b;
        acc[1][8*(3-rcnt) +: 8] = b;
        rcnt++;
        if (rcnt == 4 || last) begin
            qrx[0].push_back(acc[0]);
            qrx[1].push_back(acc[1]);
            acc[0] = '0; acc[1] = '0; rcnt = 0;
        end
        @(posedge clk); #1;
        rx_byte = b; rx_last = last; rx_byte_valid = 1'b1;
        @(negedge clk);
        while (!rxr[0]) @(negedge clk);
        @(posedge clk); #1;
        rx_byte_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 400; i++) begin
            if (qtx[0].size() == 0 && qtx[1].size() == 0 && qrx[0].size() == 0 && qrx[1].size() == 0)
                break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            check(txr[k] && rxr[k], "R9 ready after reset", {30'h0, rxr[k], txr[k]}, 32'h3);
            check(!txv[k] && !rxv[k] && !txe[k], "R9 idle after reset", {29'h0, txe[k], rxv[k], txv[k]}, 32'h0);
        end

        // R1 R2 full words, R3 partial enables
        send_word(32'h11223344, 4'hF);
        send_word(32'hA1B2C3D4, 4'b0101);
        send_word(32'h55667788, 4'b1000);
        send_word(32'h99AABBCC, 4'b0110);
        send_word(32'h0F1E2D3C, 4'b1001);
        drain();
        // R4 empty enables
        send_word(32'hDEADBEEF, 4'h0);
        // R8 with toggling ready
        rmode = 1;
        send_word(32'hCAFEF00D, 4'hF);
        send_word(32'h01020304, 4'b1110);
        send_word(32'h00000000, 4'h0);
        // R5 full receive words
        send_rx(8'h01, 1'b0); send_rx(8'h02, 1'b0); send_rx(8'h03, 1'b0); send_rx(8'h04, 1'b0);
        send_rx(8'hA5, 1'b0); send_rx(8'h5A, 1'b0); send_rx(8'hC3, 1'b0); send_rx(8'h3C, 1'b1);
        // R6 short flushes
        send_rx(8'hE1, 1'b0); send_rx(8'hE2, 1'b1);
        send_rx(8'h77, 1'b1);
        drain();
        rmode = 0;
        drain();

        // R7 clear with a stalled tx word and a half-filled rx word
        rmode = 2;
        send_word(32'h13579BDF, 4'hF);
        @(posedge clk); #1;
        rx_byte = 8'hEE; rx_byte_valid = 1'b1;
        @(posedge clk); #1;
        rx_byte = 8'hDD;
        @(posedge clk); #1;
        rx_byte_valid = 1'b0;
        clear = 1'b1;
        @(posedge clk); #1;
        clear = 1'b0;
        for (int k = 0; k < 2; k++) begin
            qtx[k].delete();
            qrx[k].delete();
        end
        @(negedge clk);
        for (int k = 0; k < 2; k++)
            check(!txv[k] && !rxv[k] && txr[k] && rxr[k], "R7 cleared",
                  {28'h0, rxr[k], txr[k], rxv[k], txv[k]}, 32'hC);
        rmode = 0;
        send_rx(8'h10, 1'b0); send_rx(8'h20, 1'b1);
        send_word(32'h2468ACE0, 4'b0011);
        drain();

        for (int k = 0; k < 2; k++) begin
            check(qtx[k].size() == 0, "R3 all tx bytes seen", qtx[k].size(), 32'h0);
            check(qrx[k].size() == 0, "R5 all rx words seen", qrx[k].size(), 32'h0);
            check(err_seen[k] == err_exp, "R4 error pulse count", err_seen[k], err_exp);
        end
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule